// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is a 256-byte, byte-addressable non-volatile memory model that answers on a two-wire I2C/SMBus bus as a target. The bus lines are sampled with the system clock. The block detects START and STOP conditions and SCL edges. It decodes a device-select byte built from a fixed 4-bit code and three strap pins. It then takes a word address, and either accepts data bytes into a 16-byte page buffer or streams array bytes back to the controller. The block drives SDA only by pulling it low, through an output enable.

Written data is held in the page buffer until the controller issues STOP. On STOP the buffered bytes go into the array and a timed internal write cycle starts. While that cycle runs, the target answers nothing on the bus. The array is seen as 16 pages of 16 bytes. Data bytes within one write transaction advance only the low four address bits, so they wrap inside the addressed page. A protect input, when high, keeps the lower half of the array (addresses below 80h) unchanged, but the bus transfer is still acknowledged. Reads advance across the whole array and wrap from FFh to 00h.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A select byte is acknowledged only when its upper four bits are 1010 and bits 3..1 equal `strap_i`; bit 0 is the direction (0 write, 1 read). Any other select byte leaves SDA released, and the target ignores the bus until the next START.
- R2: In a write, the target acknowledges the select byte, the word address and every data byte by holding SDA low through the ninth SCL clock. A single data byte followed by STOP stores that byte at the word address.
- R3: The internal write cycle begins on the STOP that ends a write carrying at least one data byte. `busy_o` is high for exactly WR_CYCLES system clocks after that STOP.
- R4: While `busy_o` is high, no select byte is acknowledged and SDA is never driven.
- R5: Successive data bytes in one write go to successive addresses that change only in the low four bits. After offset Fh the next byte goes to offset 0h of the same page.
- R6: When more than 16 data bytes are sent in one write, later bytes overwrite earlier ones at the wrapped offsets. Only the last value for each offset is stored.
- R7: A write of 2, 4 or 8 data bytes changes exactly those bytes and no others in the page.
- R8: While `wp_lo_i` is high, a write aimed at addresses 00h to 7Fh is still acknowledged but leaves the array unchanged. Addresses 80h to FFh are written whatever the value of `wp_lo_i`.
- R9: Consecutive read bytes come from consecutive addresses over the full 256-byte space, wrapping from FFh to 00h. The controller's ACK asks for another byte; its NACK ends the read.
- R10: A read select that follows a write select and a word address (through a repeated START) starts at that word address. A read select without a preceding address continues from the address after the last byte accessed.
- R11: After reset the array holds all zeros, `busy_o` is low and SDA is released.
- R12: A write that carries a word address but no data byte, followed by STOP, starts no internal write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line (resolved bus value) |
| sda_oe_o | output | 1 | Pull SDA low when 1, release when 0 |
| strap_i | input | 3 | Address strap pins compared with select bits 3..1 |
| wp_lo_i | input | 1 | Protect enable for the lower half of the array |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
Several properties are checked on every cycle. SDA stays released while the write cycle runs. `busy_o` rises only on the clock after a detected STOP and stays high for exactly the programmed cycle count. The SDA enable changes only while SCL is low. No array byte enable fires into the lower half while protection is on. Other behaviours can only be shown by the bench's scenarios, which compare read-back data with a reference array: page wrap and overwrite order, partial-page isolation, read address wrap, random versus current-address reads, and the strap-pin decode.

// File: rtl/ee_i2c_pkg.sv
package ee_i2c_pkg;
   // protocol phase of the target
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEL,
      ST_ADDR,
      ST_WDAT,
      ST_ACK,
      ST_RDAT,
      ST_RACK
   } ee_state_e;

   // fixed upper nibble of the memory select byte
   localparam logic [3:0] SEL_CODE = 4'b1010;
endpackage

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise_o = !scl_q && scl_i;
   assign scl_fall_o = scl_q && !scl_i;
   // SDA moving while SCL is held high marks a bus condition
   assign start_o    = scl_q && scl_i && sda_q && !sda_i;
   assign stop_o     = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
   parameter int DATA_W = 8,
   parameter int PAGE_W = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr_i,
   input  logic                          wr_en_i,
   input  logic [PAGE_W-1:0]             wr_idx_i,
   input  logic [DATA_W-1:0]             wr_data_i,
   output logic [(1<<PAGE_W)*DATA_W-1:0] data_o,
   output logic [(1<<PAGE_W)-1:0]        vld_o
);
   localparam int NB = 1 << PAGE_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_o <= '0;
         vld_o  <= '0;
      end else if (clr_i) begin
         vld_o <= '0;
      end else if (wr_en_i) begin
         // a repeated offset simply overwrites: last byte wins
         data_o[wr_idx_i*DATA_W +: DATA_W] <= wr_data_i;
         vld_o[wr_idx_i]                    <= 1'b1;
      end
   end

   if (NB < 2) begin : g_bad_page
      $error("ee_page_buf: page must hold at least two bytes");
   end
endmodule

// File: rtl/ee_wr_timer.sv
module ee_wr_timer #(
   parameter int CYCLES = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic busy_o
);
   localparam int TW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

   logic [TW-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n)              remain <= '0;
      else if (load_i)         remain <= TW'(CYCLES);
      else if (remain != '0)   remain <= remain - TW'(1);
   end

   assign busy_o = (remain != '0);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("ee_wr_timer: write time must be at least one cycle");
   end
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
   import ee_i2c_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int PAGE_W    = 4,
   parameter int WR_CYCLES = 250000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   input  logic [2:0] strap_i,
   input  logic       wp_lo_i,
   output logic       busy_o
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int NB    = 1 << PAGE_W;
   localparam int CNT_W = $clog2(DATA_W + 1);

   logic              scl_rise, scl_fall, start_ev, stop_ev;
   ee_state_e         st, nxt;
   logic [DATA_W-1:0] shreg, rd_byte;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] ptr;
   logic              oe_q, mack, ptr_hi, blocked;
   logic              byte_done, sel_hit, buf_we, buf_clr, commit;
   logic [DATA_W-1:0] mem [DEPTH];
   logic [NB*DATA_W-1:0] buf_data;
   logic [NB-1:0]     buf_vld, byte_we;

   i2c_cond_det u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start_ev), .stop_o(stop_ev)
   );

   assign byte_done = scl_fall && (cnt == CNT_W'(DATA_W));
   // R1: fixed code plus strap match; R4: no answer while busy
   assign sel_hit   = (shreg[DATA_W-1 -: 4] == SEL_CODE) &&
                      (shreg[DATA_W-5 -: 3] == strap_i) && !busy_o;
   assign buf_we    = (st == ST_WDAT) && byte_done;
   assign buf_clr   = ((st == ST_SEL) && byte_done && sel_hit && !shreg[0]) || commit;
   // R3/R12: commit only when data was buffered
   assign commit    = stop_ev && (buf_vld != '0);
   assign ptr_hi    = ptr[ADDR_W-1];
   assign blocked   = wp_lo_i && !ptr_hi;  // R8
   assign rd_byte   = mem[ptr];

   ee_page_buf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr_i(buf_clr), .wr_en_i(buf_we),
      .wr_idx_i(ptr[PAGE_W-1:0]), .wr_data_i(shreg),
      .data_o(buf_data), .vld_o(buf_vld)
   );

   ee_wr_timer #(.CYCLES(WR_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load_i(commit), .busy_o(busy_o)
   );

   for (genvar g = 0; g < NB; g++) begin : g_we
      assign byte_we[g] = commit && buf_vld[g] && !blocked;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;   // R11
      end else begin
         for (int i = 0; i < NB; i++)
            if (byte_we[i])
               mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= buf_data[i*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         nxt   <= ST_IDLE;
         shreg <= '0;
         cnt   <= '0;
         ptr   <= '0;
         oe_q  <= 1'b0;
         mack  <= 1'b0;
      end else if (start_ev) begin
         st   <= ST_SEL;
         cnt  <= '0;
         oe_q <= 1'b0;
      end else if (stop_ev) begin
         st   <= ST_IDLE;
         oe_q <= 1'b0;
      end else begin
         unique case (st)
            ST_SEL, ST_ADDR, ST_WDAT: begin
               if (scl_rise) begin
                  shreg <= {shreg[DATA_W-2:0], sda_i};
                  cnt   <= cnt + CNT_W'(1);
               end else if (byte_done) begin
                  cnt <= '0;
                  if (st == ST_SEL) begin
                     if (sel_hit) begin
                        oe_q <= 1'b1;
                        st   <= ST_ACK;
                        nxt  <= shreg[0] ? ST_RDAT : ST_ADDR;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end else if (st == ST_ADDR) begin
                     ptr  <= shreg[ADDR_W-1:0];
                     oe_q <= 1'b1;
                     st   <= ST_ACK;
                     nxt  <= ST_WDAT;
                  end else begin
                     // R5: advance within the page only
                     ptr  <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                     oe_q <= 1'b1;
                     st   <= ST_ACK;
                     nxt  <= ST_WDAT;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  cnt <= '0;
                  st  <= nxt;
                  if (nxt == ST_RDAT) begin
                     shreg <= rd_byte;
                     oe_q  <= !rd_byte[DATA_W-1];
                  end else begin
                     oe_q <= 1'b0;
                  end
               end
            end
            ST_RDAT: begin
               if (scl_rise) begin
                  cnt <= cnt + CNT_W'(1);
               end else if (scl_fall) begin
                  if (cnt == CNT_W'(DATA_W)) begin
                     oe_q <= 1'b0;
                     ptr  <= ptr + ADDR_W'(1);   // R9: full-space increment
                     st   <= ST_RACK;
                  end else begin
                     shreg <= shreg << 1;
                     oe_q  <= !shreg[DATA_W-2];
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  mack <= !sda_i;
               end else if (scl_fall) begin
                  if (mack) begin
                     shreg <= rd_byte;
                     oe_q  <= !rd_byte[DATA_W-1];
                     cnt   <= '0;
                     st    <= ST_RDAT;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign sda_oe_o = oe_q;

   if (DATA_W < ADDR_W || DATA_W < 8) begin : g_bad_width
      $error("eeprom_i2c_target: data byte must carry the select and word address");
   end
   if (PAGE_W >= ADDR_W) begin : g_bad_page
      $error("eeprom_i2c_target: page must be smaller than the array");
   end
endmodule

// File: rtl/ee_i2c_checker.sv
module ee_i2c_checker #(
   parameter int NB        = 16,
   parameter int WR_CYCLES = 250000
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_i,
   input logic          sda_oe,
   input logic          busy,
   input logic          wp_lo,
   input logic          stop_ev,
   input logic [NB-1:0] byte_we,
   input logic          page_hi
);
   int unsigned run_len;

   always_ff @(posedge clk) begin
      if (!rst_n)    run_len <= 0;
      else if (busy) run_len <= run_len + 1;
      else           run_len <= 0;
   end

   // R4: bus left alone during the internal write
   p_quiet_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe);

   // R3: write cycle is started by a STOP
   p_busy_after_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_ev));

   // R3: write cycle length
   p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == WR_CYCLES));

   // R2: SDA drive changes only while SCL is low
   p_oe_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !$past(scl_i));

   // R8: no byte enable into the protected half
   p_prot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_lo && !page_hi) |-> (byte_we == '0));
endmodule

bind eeprom_i2c_target ee_i2c_checker #(.NB(NB), .WR_CYCLES(WR_CYCLES)) chk_i (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe_o), .busy(busy_o),
   .wp_lo(wp_lo_i), .stop_ev(stop_ev), .byte_we(byte_we), .page_hi(ptr_hi)
);

// File: tb/eeprom_i2c_target_tb.sv
module eeprom_i2c_target_tb_top;
   localparam int WRC = 300;
   localparam int Q   = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [2:0] strap = 3'b101;
   logic       wp = 1'b0;
   logic       sda_oe, busy;
   wire        sda_line = sda_m & ~sda_oe;

   always #10 clk = ~clk;   // 50 MHz

   eeprom_i2c_target #(.WR_CYCLES(WRC)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .strap_i(strap), .wp_lo_i(wp), .busy_o(busy)
   );

   int checks = 0;
   int errors = 0;
   logic [7:0] model [256];
   int mptr = 0;
   logic [7:0] wdat [32];
   int busy_run = 0;
   int last_busy = 0;

   always @(posedge clk) begin
      if (busy) busy_run++;
      else begin
         if (busy_run > 0) last_busy = busy_run;
         busy_run = 0;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   task automatic q(input int n);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; q(1); scl_m = 1'b1; q(1); sda_m = 1'b0; q(1); scl_m = 1'b0; q(1);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; q(1); scl_m = 1'b1; q(1); sda_m = 1'b1; q(1);
   endtask

   task automatic wbyte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; q(1); scl_m = 1'b1; q(2); scl_m = 1'b0; q(1);
      end
      sda_m = 1'b1; q(1); scl_m = 1'b1; q(1); ack = !sda_line; q(1); scl_m = 1'b0; q(1);
   endtask

   task automatic rbyte(input bit mack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; q(1); scl_m = 1'b1; q(1); b[i] = sda_line; q(1); scl_m = 1'b0; q(1);
      end
      sda_m = !mack; q(1); scl_m = 1'b1; q(2); scl_m = 1'b0; q(1); sda_m = 1'b1;
   endtask

   function automatic logic [7:0] sel(input bit rd);
      return {4'b1010, strap, rd};
   endfunction

   // reference page write: low offset wraps, last byte wins, protect on lower half
   task automatic model_write(input int a, input int n);
      logic [7:0] pb [16];
      bit pv [16];
      int lo = a % 16;
      int pg = a / 16;
      for (int j = 0; j < 16; j++) begin pv[j] = 1'b0; pb[j] = 8'h00; end
      for (int i = 0; i < n; i++) begin
         pb[lo] = wdat[i]; pv[lo] = 1'b1; lo = (lo + 1) % 16;
      end
      if (n > 0 && !(wp && pg < 8))
         for (int j = 0; j < 16; j++) if (pv[j]) model[pg*16 + j] = pb[j];
      mptr = pg * 16 + lo;
   endtask

   task automatic do_write(input int a, input int n, input string req);
      bit ack;
      bus_start();
      wbyte(sel(1'b0), ack); chk(ack, "R2 select ack", ack, 1);
      wbyte(8'(a), ack);     chk(ack, "R2 address ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         wbyte(wdat[i], ack);
         chk(ack, (wp && a < 128) ? "R8 protected data ack" : req, ack, 1);
      end
      bus_stop();
      model_write(a, n);
      repeat (3) @(negedge clk);
      if (n == 0) begin
         chk(!busy, "R12 no write cycle without data", busy, 0);
      end else begin
         chk(busy, "R3 busy after STOP", busy, 1);
         bus_start();
         wbyte(sel(1'b0), ack); chk(!ack, "R4 select ignored while busy", ack, 0);
         bus_stop();
         while (busy) @(negedge clk);
         repeat (3) @(negedge clk);
         chk(last_busy == WRC, "R3 write cycle length", last_busy, WRC);
      end
   endtask

   task automatic do_read(input int a, input bit set_addr, input int n, input string req);
      bit ack;
      logic [7:0] b;
      if (set_addr) begin
         bus_start();
         wbyte(sel(1'b0), ack); chk(ack, "R10 select ack", ack, 1);
         wbyte(8'(a), ack);     chk(ack, "R10 address ack", ack, 1);
         mptr = a;
      end
      bus_start();
      wbyte(sel(1'b1), ack); chk(ack, "R10 read select ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         rbyte(i < n - 1, b);
         chk(b == model[mptr], req, b, model[mptr]);
         mptr = (mptr + 1) % 256;
      end
      bus_stop();
   endtask

   function automatic int pick_len(input int k);
      case (k % 5)
         0: return 1;
         1: return 2;
         2: return 4;
         3: return 8;
         default: return 16;
      endcase
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
      $finish;
   end

   initial begin
      bit ack;
      void'($urandom(32'd4021));
      for (int i = 0; i < 256; i++) model[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R11 reset state
      chk(!busy, "R11 busy low after reset", busy, 0);
      chk(!sda_oe, "R11 SDA released after reset", sda_oe, 0);
      do_read(8'h00, 1'b1, 4, "R11 array zero after reset");

      // R1 select decode
      bus_start();
      wbyte({4'b1010, strap ^ 3'b001, 1'b0}, ack); chk(!ack, "R1 wrong strap nacked", ack, 0);
      bus_stop();
      bus_start();
      wbyte({4'b1011, strap, 1'b0}, ack); chk(!ack, "R1 wrong code nacked", ack, 0);
      bus_stop();
      strap = 3'b010;
      q(2);
      bus_start();
      wbyte(sel(1'b0), ack); chk(ack, "R1 new strap acked", ack, 1);
      bus_stop();

      // R2 single byte write
      wdat[0] = 8'h5A;
      do_write(8'hC3, 1, "R2 data ack");
      do_read(8'hC3, 1'b1, 1, "R2 byte write stored");

      // R12 address only
      do_write(8'h44, 0, "R12 none");

      // R5 page wrap from mid page
      for (int i = 0; i < 16; i++) wdat[i] = 8'(8'h10 + i);
      do_write(8'h97, 16, "R5 data ack");
      do_read(8'h90, 1'b1, 16, "R5 page wrap contents");
      do_read(8'h8F, 1'b1, 2, "R5 neighbour page untouched");

      // R6 overrun past 16 bytes
      for (int i = 0; i < 20; i++) wdat[i] = 8'(8'hE0 + i);
      do_write(8'hA0, 20, "R6 data ack");
      do_read(8'hA0, 1'b1, 16, "R6 last byte wins");

      // R7 partial pages
      for (int i = 0; i < 8; i++) wdat[i] = 8'(8'h71 + 3 * i);
      do_write(8'hB2, 2, "R7 data ack");
      do_write(8'hB4, 4, "R7 data ack");
      do_write(8'hB8, 8, "R7 data ack");
      do_read(8'hB0, 1'b1, 16, "R7 partial page isolation");

      // R8 protection
      wp = 1'b1;
      for (int i = 0; i < 4; i++) wdat[i] = 8'(8'hC0 + i);
      do_write(8'h10, 4, "R8 data ack");
      do_read(8'h10, 1'b1, 4, "R8 lower half unchanged");
      do_write(8'h80, 4, "R8 data ack");
      do_read(8'h80, 1'b1, 4, "R8 upper half written");
      wp = 1'b0;
      do_write(8'h10, 4, "R8 data ack");
      do_read(8'h10, 1'b1, 4, "R8 lower half written when off");

      // R9 wrap across the top of the array
      for (int i = 0; i < 4; i++) wdat[i] = 8'(8'h3C + i);
      do_write(8'hFE, 2, "R9 data ack");
      do_read(8'hFC, 1'b1, 6, "R9 read wraps FFh to 00h");

      // R10 current address read continues
      do_read(8'h20, 1'b1, 2, "R10 random read");
      do_read(0, 1'b0, 3, "R10 current address read");

      // constrained random mix
      for (int t = 0; t < 10; t++) begin
         int a = int'($urandom % 256);
         int n = pick_len(int'($urandom % 5));
         wp = 1'($urandom % 2);
         for (int i = 0; i < n; i++) wdat[i] = 8'($urandom);
         do_write(a, n, "R7 random data ack");
         do_read((a / 16) * 16, 1'b1, 16, "R5 random page read-back");
      end
      wp = 1'b0;

      report();
      $finish;
   end
endmodule